// File: doc/BRIEF.md
# Sixteen-bit timer channel with compare, capture, PWM and quadrature counting

The block is a single 16-bit timer channel. It has one counter and two general registers. The counter advances on a clock enable picked from eight prescaled enable inputs. Each general register works either as a compare register or as a capture register:

- In compare mode, a match can change the matching register's waveform output. The change can be a one-time set or clear, or a toggle.
- In capture mode, a selected edge on that register's input pin copies the counter into the register.

A PWM mode uses the first register as the period, with the counter cleared after that value. The second register sets the duty point. A phase-counting mode ignores the prescaler and counts up or down from two quadrature encoder inputs.

Software reaches everything through a simple register port:

| Address | Register | Content |
|---|---|---|
| 0 | control | clock select, mode, run, clear-on-match |
| 1 | pin setup | per-register function and output level |
| 2 | counter | current count |
| 3 | general register 0 | compare or capture value |
| 4 | general register 1 | compare or capture value |
| 5 | status | event flags, write-1-to-clear |
| 6 | interrupt enable | one enable per status flag |

Writes happen on a clock edge with `bus_wr` high. Reads are combinational from `bus_addr`. One interrupt line is the OR of the enabled status flags.

Top module: `tmr16_chan`

## Requirements
- R1: After reset the counter, both general registers, status, interrupt enables, both waveform outputs and `irq` are 0.
- R2: Outside phase mode, the counter advances by one on each clock where run is set and `tick_src[csel]` is 1. Enable bits other than the selected one, or any bit while run is clear, do not advance it. The control register (address 0) holds: csel in bits [2:0], mode in bits [4:3], run in bit 5 and clear-on-match in bit 6. Mode encodings: 00 normal, 01 PWM, 10 phase counting; 11 behaves as normal.
- R3: An up-count from 16'hFFFF that is not a match clear wraps to 0 and sets status bit 2 (overflow).
- R4: A register i in compare mode has a match on a count step taken while the counter equals it. A match sets status bit i. It also applies the action in the register's pin-setup field: 01 drive 0, 10 drive 1 (both one-shot), 11 toggle, 00 leave the output.
  - The pin-setup register (address 1) holds a 4-bit field per register at bits [4i+3:4i]:
    - bit 0: 1 for capture mode.
    - bits [2:1]: compare action, or capture edge.
    - bit 3: output level loaded on write.
- R5: In normal mode with clear-on-match set, a step taken while the counter equals general register 0 takes the counter to 0. The count cycle then has general register 0 plus one states.
- R6: In capture mode, an edge on `cap_in[i]` loads the counter value into register i and sets status bit i. The input first passes a two-flop synchronizer. Edge select: 01 rising, 10 falling, 11 both. An edge that is not selected changes nothing.
- R7: In PWM mode the counter clears after reaching general register 0. `wave_out[1]` is 1 exactly while the counter is below general register 1. A duty value of 0 gives a constant 0; a value above the period gives a constant 1.
- R8: In phase mode with run set, the synchronized phases A and B count. A change of A alone counts up when A now differs from B. A change of B alone counts up when the two are now equal. Other single changes count down. A change of both in one sample is ignored.
- R9: A down-count from 0 wraps to 16'hFFFF and sets status bit 3 (underflow).
- R10: Writing 1 to a status bit (address 5) clears it. A new event in the same cycle wins. `irq` is 1 exactly when some status bit and its enable bit (address 6) are both 1.
- R11: A write to the pin-setup register loads each `wave_out[i]` with bit 4i+3 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 8 | Eight prescaled count enables |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cap_in | input | 2 | Capture inputs, one per general register |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| wave_out | output | 2 | Waveform outputs, one per general register |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches four kinds of rule on every cycle:

- Phase mode moves the counter by at most one per sample.
- Wrap-around in either direction sets the matching flag.
- A capture loads the counter value of that cycle.
- Status flags never drop without a clear write, and a fully masked channel never raises `irq`.

The other rules depend on a configured sequence, so only the bench scenarios show them:

- the clock-source selection;
- the compare actions, including one-shot hold versus toggle;
- the clear-on-match period;
- the PWM duty extremes;
- the edge selection of capture;
- the direction decode of the quadrature phases.

// File: rtl/tmr16_chan.sv
module tmr16_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   tick_src,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [1:0]   cap_in,
  input  logic         enc_a,
  input  logic         enc_b,
  output logic [1:0]   wave_out,
  output logic         irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_PIN = 3'd1, A_CNT = 3'd2,
                         A_GR0 = 3'd3, A_GR1 = 3'd4, A_STS = 3'd5, A_IEN = 3'd6;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [6:0]   ctrl;
  logic [7:0]   pin;
  logic [3:0]   sts, ien;
  logic [W-1:0] cnt, cnt_nxt;
  logic [W-1:0] gr [2];
  logic [1:0]   cs1, cs2, cp;
  logic [2:0]   ea, eb;

  logic [1:0] mode;
  logic run, pwm, phase, tick, da, db, ok, fwd, up_step, dn_step, up, dn, step, clr, ovf, udf;
  logic [1:0] rise, fall, cap_ev, match;

  assign mode  = ctrl[4:3];
  assign run   = ctrl[5];
  assign pwm   = mode == 2'b01;
  assign phase = mode == 2'b10;
  assign tick  = run && !phase && tick_src[ctrl[2:0]];

  assign da      = ea[1] ^ ea[2];
  assign db      = eb[1] ^ eb[2];
  assign ok      = run && phase && (da ^ db);
  assign fwd     = da ? (ea[1] ^ eb[1]) : ~(ea[1] ^ eb[1]);
  assign up_step = ok && fwd;
  assign dn_step = ok && !fwd;

  assign up   = tick || up_step;
  assign dn   = dn_step;
  assign step = up || dn;
  assign clr  = tick && (cnt == gr[0]) && (pwm || ctrl[6]);
  assign ovf  = up && !clr && (cnt == ALL1);
  assign udf  = dn && (cnt == '0);

  assign rise = cs2 & ~cp;
  assign fall = ~cs2 & cp;

  for (genvar i = 0; i < 2; i++) begin : g_ev
    assign cap_ev[i] = pin[4*i] && ((pin[4*i+1] && rise[i]) || (pin[4*i+2] && fall[i]));
    assign match[i]  = !pin[4*i] && step && (cnt == gr[i]);
  end

  always_comb begin
    if (bus_wr && bus_addr == A_CNT) cnt_nxt = bus_wdata;
    else if (clr)                    cnt_nxt = '0;
    else if (up)                     cnt_nxt = cnt + 1'b1;
    else if (dn)                     cnt_nxt = cnt - 1'b1;
    else                             cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs1 <= '0; cs2 <= '0; cp <= '0;
      ea <= '0;  eb <= '0;
    end else begin
      cs1 <= cap_in; cs2 <= cs1; cp <= cs2;
      ea <= {ea[1:0], enc_a};
      eb <= {eb[1:0], enc_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; pin <= '0; ien <= '0; sts <= '0; cnt <= '0;
      gr[0] <= '0; gr[1] <= '0; wave_out <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[6:0];
      if (bus_wr && bus_addr == A_PIN)  pin  <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_IEN)  ien  <= bus_wdata[3:0];
      sts <= (sts & ~((bus_wr && bus_addr == A_STS) ? bus_wdata[3:0] : 4'd0))
             | {udf, ovf, match | cap_ev};
      for (int i = 0; i < 2; i++) begin
        if (bus_wr && bus_addr == A_GR0 + 3'(i)) gr[i] <= bus_wdata;
        else if (cap_ev[i])                      gr[i] <= cnt;
        if (bus_wr && bus_addr == A_PIN)         wave_out[i] <= bus_wdata[4*i+3];
        else if (pwm && i == 1)                  wave_out[i] <= cnt_nxt < gr[1];
        else if (match[i]) begin
          case (pin[4*i+1 +: 2])
            2'b01:   wave_out[i] <= 1'b0;
            2'b10:   wave_out[i] <= 1'b1;
            2'b11:   wave_out[i] <= ~wave_out[i];
            default: wave_out[i] <= wave_out[i];
          endcase
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = W'(ctrl);
      A_PIN:   bus_rdata = W'(pin);
      A_CNT:   bus_rdata = cnt;
      A_GR0:   bus_rdata = gr[0];
      A_GR1:   bus_rdata = gr[1];
      A_STS:   bus_rdata = W'(sts);
      A_IEN:   bus_rdata = W'(ien);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(sts & ien);
endmodule

// File: rtl/tmr16_chan_chk.sv
module tmr16_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] cnt,
  input logic [3:0]   sts,
  input logic [3:0]   ien,
  input logic         irq,
  input logic [1:0]   mode,
  input logic         up_step,
  input logic         dn_step,
  input logic         cap0,
  input logic [W-1:0] gr0
);
  logic cnt_wr;
  assign cnt_wr = bus_wr && bus_addr == 3'd2;

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !cnt_wr) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_step && cnt == '0 && !cnt_wr) |=> (cnt == {W{1'b1}} && sts[3]));

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (up_step && cnt == {W{1'b1}} && !cnt_wr) |=> (cnt == '0 && sts[2]));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap0 && !(bus_wr && bus_addr == 3'd3)) |=> (gr0 == $past(cnt) && sts[0]));

  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd5) |=> ((sts & $past(sts)) == $past(sts)));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'd0) |-> !irq);
endmodule

bind tmr16_chan tmr16_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnt(cnt), .sts(sts), .ien(ien), .irq(irq), .mode(mode),
  .up_step(up_step), .dn_step(dn_step), .cap0(cap_ev[0]), .gr0(gr[0])
);

// File: tb/tb_tmr16_chan.sv
module tb_tmr16_chan;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  tick_src = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [1:0]  cap_in = 0;
  logic        enc_a = 0, enc_b = 0;
  logic [1:0]  wave_out;
  logic        irq;

  tmr16_chan dut (.*);

  always #5 clk = ~clk;

  typedef struct { int kind; logic [15:0] exp; string rq; } item_t;
  item_t q[$];
  event smp;
  int checks = 0, errors = 0;
  bit done = 0;

  initial forever begin
    @(smp);
    #1;
    begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {14'd0, wave_out} : {15'd0, irq};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.rq, act, it.exp);
      end
    end
  end

  task automatic expect_v(int kind, logic [2:0] a, logic [15:0] e, string rq);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = kind; it.exp = e; it.rq = rq;
    q.push_back(it);
    -> smp;
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); tick_src = m;
    @(negedge clk); tick_src = 0;
  endtask

  task automatic step(); pulse(8'h01); endtask

  task automatic enc(logic a, logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic cap(logic [1:0] v);
    @(negedge clk); cap_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_v(0, 3'd2, 16'h0, "R1 count");
    expect_v(0, 3'd3, 16'h0, "R1 gr0");
    expect_v(0, 3'd5, 16'h0, "R1 status");
    expect_v(1, 3'd0, 16'h0, "R1 wave");
    expect_v(2, 3'd0, 16'h0, "R1 irq");

    // R2 clock source selection
    wr(3'd0, 16'h25);
    pulse(8'h04);
    expect_v(0, 3'd2, 16'd0, "R2 unselected source");
    pulse(8'h20);
    expect_v(0, 3'd2, 16'd1, "R2 selected source");
    pulse(8'h20); pulse(8'hFF);
    expect_v(0, 3'd2, 16'd3, "R2 repeated steps");
    wr(3'd0, 16'h05);
    pulse(8'h20);
    expect_v(0, 3'd2, 16'd3, "R2 run clear");

    // R4 compare actions
    wr(3'd2, 16'd0); wr(3'd3, 16'd3); wr(3'd4, 16'd2);
    wr(3'd5, 16'hF); wr(3'd1, 16'h46);
    wr(3'd0, 16'h20);
    step(); step();
    expect_v(0, 3'd5, 16'h0, "R4 no match yet");
    expect_v(1, 3'd0, 16'h0, "R4 outputs idle");
    step();
    expect_v(0, 3'd5, 16'h2, "R4 gr1 match flag");
    expect_v(1, 3'd0, 16'h2, "R4 one-shot set");
    step();
    expect_v(0, 3'd5, 16'h3, "R4 gr0 match flag");
    expect_v(1, 3'd0, 16'h3, "R4 toggle");
    wr(3'd2, 16'd3);
    step();
    expect_v(1, 3'd0, 16'h2, "R4 toggle back, one-shot holds");

    // R5 clear on match
    wr(3'd0, 16'h00); wr(3'd2, 16'd0); wr(3'd3, 16'd2);
    wr(3'd0, 16'h60);
    step(); step();
    expect_v(0, 3'd2, 16'd2, "R5 reaches gr0");
    step();
    expect_v(0, 3'd2, 16'd0, "R5 cleared");
    step();
    expect_v(0, 3'd2, 16'd1, "R5 restart");

    // R3 overflow, R10 flags and irq
    wr(3'd0, 16'h00); wr(3'd5, 16'hF); wr(3'd2, 16'hFFFF);
    wr(3'd0, 16'h20);
    step();
    expect_v(0, 3'd2, 16'd0, "R3 wrap");
    expect_v(0, 3'd5, 16'h4, "R3 overflow flag");
    expect_v(2, 3'd0, 16'h0, "R10 masked irq");
    wr(3'd6, 16'h4);
    expect_v(2, 3'd0, 16'h1, "R10 enabled irq");
    wr(3'd5, 16'h4);
    expect_v(0, 3'd5, 16'h0, "R10 write-1 clear");
    expect_v(2, 3'd0, 16'h0, "R10 irq drops");
    wr(3'd6, 16'h0);

    // R7 PWM
    wr(3'd0, 16'h00); wr(3'd2, 16'd0); wr(3'd3, 16'd4); wr(3'd4, 16'd2);
    wr(3'd1, 16'h00);
    wr(3'd0, 16'h28);
    expect_v(1, 3'd0, 16'h2, "R7 high at count 0");
    for (int k = 1; k <= 5; k++) begin
      step();
      expect_v(0, 3'd2, 16'(k % 5), "R7 period count");
      expect_v(1, 3'd0, (k % 5) < 2 ? 16'h2 : 16'h0, "R7 duty");
    end
    wr(3'd4, 16'd0);
    step();
    expect_v(1, 3'd0, 16'h0, "R7 zero duty");
    step(); step();
    expect_v(1, 3'd0, 16'h0, "R7 zero duty at period start");
    wr(3'd4, 16'd7);
    step();
    expect_v(1, 3'd0, 16'h2, "R7 full duty");
    step(); step(); step();
    expect_v(1, 3'd0, 16'h2, "R7 full duty at period end");

    // R6 capture
    wr(3'd0, 16'h00); wr(3'd5, 16'hF); wr(3'd4, 16'hAAAA);
    wr(3'd1, 16'h53); wr(3'd2, 16'h1234);
    cap(2'b01);
    expect_v(0, 3'd3, 16'h1234, "R6 rising capture");
    expect_v(0, 3'd5, 16'h1, "R6 capture flag");
    wr(3'd2, 16'h5678);
    cap(2'b11);
    expect_v(0, 3'd4, 16'hAAAA, "R6 unselected rising");
    cap(2'b00);
    expect_v(0, 3'd4, 16'h5678, "R6 falling capture");
    expect_v(0, 3'd3, 16'h1234, "R6 unselected falling");
    wr(3'd1, 16'h57); wr(3'd2, 16'h0042);
    cap(2'b01);
    cap(2'b00);
    expect_v(0, 3'd3, 16'h0042, "R6 both edges");

    // R11 output level on pin-setup write
    wr(3'd1, 16'h88);
    expect_v(1, 3'd0, 16'h3, "R11 both high");
    wr(3'd1, 16'h08);
    expect_v(1, 3'd0, 16'h1, "R11 only out0");

    // R8 phase counting
    wr(3'd1, 16'h00); wr(3'd5, 16'hF);
    wr(3'd2, 16'd10); wr(3'd0, 16'h30);
    enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
    expect_v(0, 3'd2, 16'd14, "R8 A leads up");
    enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
    expect_v(0, 3'd2, 16'd10, "R8 B leads down");
    enc(1, 1); enc(0, 0);
    expect_v(0, 3'd2, 16'd10, "R8 double change ignored");
    pulse(8'hFF);
    expect_v(0, 3'd2, 16'd10, "R8 prescaler ignored");

    // R9 underflow
    wr(3'd2, 16'd0);
    enc(0, 1);
    expect_v(0, 3'd2, 16'hFFFF, "R9 wrap");
    expect_v(0, 3'd5, 16'h8, "R9 underflow flag");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule